// File: doc/BRIEF.md
# Synchronous Serial Port Master

This block is a serial master for SPI-style peripherals, programmed through a small 16-bit register bus. Software puts frames into a transmit queue by writing the data register. The block sends each frame most significant bit first on `mosi` and, on the same clock edges, collects one frame from `miso`. The received frame goes into a receive queue, and software drains that queue by reading the data register. Both queues are 16 bits wide and 8 entries deep.

A control word sets the frame length from 4 to 16 bits, the idle level of the serial clock and the edge on which data is sampled. A second control word holds the port enable. The serial clock rate comes from a prescale register together with a rate factor in the control word. A status word reports the fill state of both queues and a busy flag. Four fixed identification words let software confirm the block before it uses it. One active-low select line frames every burst of back-to-back frames.

Registers sit on a 4-byte stride, and only word-aligned addresses decode. Register words by byte offset: 0x000 format control, 0x004 port control, 0x008 data, 0x00C status, 0x010 prescale, 0xFE0..0xFEC identification. Every other offset reads zero and ignores writes.

Top module: `ssp_master`

## Requirements
- R1: After reset the status word reads 0x0003 and `cs_n` is high. Status bits are: bit 0 transmit queue empty, bit 1 transmit queue not full, bit 2 receive queue not empty, bit 3 receive queue full, bit 4 busy. All other bits are zero.
- R2: The identification words at 0xFE0, 0xFE4, 0xFE8 and 0xFEC read 0x0022, 0x0010, 0x0004 and 0x0000.
- R3: A frame is format-control bits 3:0 plus one bits long. A setting below 3 gives a 4-bit frame. Only the low frame-length bits of a queued word are sent, most significant first.
- R4: Format-control bit 6 sets the idle level of `sck`. With format-control bit 7 clear, `miso` is sampled on the first edge of each bit and `mosi` changes on the second edge. With bit 7 set, `mosi` changes on the first edge and `miso` is sampled on the second.
- R5: Each frame sent places exactly one received frame in the receive queue, in arrival order. The frame is right-justified with the upper bits zero. Reading the data register returns the oldest entry and removes it.
- R6: Each half period of `sck` lasts max(prescale[7:1],1) × (rate+1) clock cycles. The rate factor is format-control bits 15:8.
- R7: Port-control bit 1 enables the port. While it is clear, no frame starts and `cs_n` stays high, while queued words are kept.
- R8: Busy reads 1 while a frame is in progress or while the port is enabled and the transmit queue is not empty. Otherwise it reads 0.
- R9: A data write while the transmit queue holds 8 words is dropped.
- R10: A frame that arrives while the receive queue holds 8 words is discarded. A data read from an empty receive queue returns 0.
- R11: `cs_n` falls before the first `sck` edge of a burst. It stays low between back-to-back frames and rises only after the transmit queue is empty and the last frame has finished.
- R12: The format-control, port-control and prescale registers read back what was written. Format-control bits 5:4, port-control bits other than bit 1, and prescale bits 15:8 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 12 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at the data offset) |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select |

## Verification
A bench-side slave model returns a different computed word for every frame and records what it samples on `mosi`. The main function is swept over all four clock modes and the frame lengths 4, 7, 8 and 16, with three back-to-back frames each. The mode sweep separates sample edges from change edges, because a wrong edge shifts every bit by one. The length sweep separates MSB alignment and right-justification from plain 8-bit behaviour. Further runs cover:
- a length setting below the minimum;
- two clock divisor settings, measured as the gap between `sck` edges;
- a fill of nine words into a disabled port, which shows the transmit drop, the receive discard, the empty read returning zero, and that nothing moves while the port is off.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 12;

    // word offsets (byte address >> 2)
    localparam logic [9:0] W_FMT   = 10'h000;
    localparam logic [9:0] W_PORT  = 10'h001;
    localparam logic [9:0] W_DATA  = 10'h002;
    localparam logic [9:0] W_STAT  = 10'h003;
    localparam logic [9:0] W_PRESC = 10'h004;
    localparam logic [9:0] W_ID0   = 10'h3F8;
    localparam logic [9:0] W_ID1   = 10'h3F9;
    localparam logic [9:0] W_ID2   = 10'h3FA;
    localparam logic [9:0] W_ID3   = 10'h3FB;

    localparam logic [15:0] ID0_VAL = 16'h0022;
    localparam logic [15:0] ID1_VAL = 16'h0010;
    localparam logic [15:0] ID2_VAL = 16'h0004;
    localparam logic [15:0] ID3_VAL = 16'h0000;

    localparam logic [15:0] FMT_WMASK = 16'hFFCF;
    localparam int          PORT_EN_BIT = 1;

    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_RUN  = 2'd1,
        SH_TAIL = 2'd2
    } shift_state_e;

    typedef struct packed {
        logic [7:0] rate;
        logic       cpha;
        logic       cpol;
        logic [1:0] rsvd;
        logic [3:0] size_m1;
    } fmt_t;

    typedef struct packed {
        logic [10:0] zero;
        logic        busy;
        logic        rx_full;
        logic        rx_nempty;
        logic        tx_nfull;
        logic        tx_empty;
    } status_t;

    function automatic logic [4:0] frame_len(input logic [3:0] size_m1);
        if (size_m1 < 4'd3) return 5'd4;
        return {1'b0, size_m1} + 5'd1;
    endfunction

    function automatic logic [15:0] half_len(input logic [7:0] presc, input logic [7:0] rate);
        logic [15:0] units;
        units = {9'd0, presc[7:1]};
        if (units == 16'd0) units = 16'd1;
        return units * ({8'd0, rate} + 16'd1);
    endfunction

endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CMAX = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CMAX);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = empty ? '0 : mem[rp_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R9
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CMAX);

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [3:0]        size_m1,
    input  logic [15:0]       half,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              cs_n,
    output logic              active
);
    shift_state_e st_q;
    logic [15:0]  tmr_q, half_q;
    logic [5:0]   edge_q;
    logic [4:0]   nb_q;
    logic         cpha_q, cpol_q;
    logic         sck_q, mosi_q, cs_q;
    logic [15:0]  tx_sh_q;
    logic [14:0]  rx_sh_q;
    logic         push_q;
    logic [15:0]  word_q;

    logic         tick, load_now, leading, sample_edge;
    logic [4:0]   nb_new;
    logic [15:0]  aligned;
    logic [5:0]   last_edge, last_sample;
    logic [15:0]  rx_next;

    assign tick        = (tmr_q == half_q - 16'd1);
    assign load_now    = en && tx_valid &&
                         ((st_q == SH_IDLE) || (st_q == SH_TAIL && tick));
    assign nb_new      = frame_len(size_m1);
    assign aligned     = tx_data << (5'd16 - nb_new);
    assign last_edge   = {nb_q, 1'b0} - 6'd1;
    assign last_sample = cpha_q ? last_edge : last_edge - 6'd1;
    assign leading     = !edge_q[0];
    assign sample_edge = leading ^ cpha_q;
    assign rx_next     = {rx_sh_q, miso};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SH_IDLE;
            tmr_q   <= '0;
            half_q  <= 16'd1;
            edge_q  <= '0;
            nb_q    <= 5'd4;
            cpha_q  <= 1'b0;
            cpol_q  <= 1'b0;
            sck_q   <= 1'b0;
            mosi_q  <= 1'b0;
            cs_q    <= 1'b1;
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            push_q  <= 1'b0;
            word_q  <= '0;
        end else begin
            push_q <= 1'b0;
            if (load_now) begin
                st_q    <= SH_RUN;
                cs_q    <= 1'b0;
                tmr_q   <= '0;
                edge_q  <= '0;
                nb_q    <= nb_new;
                cpha_q  <= cpha;
                cpol_q  <= cpol;
                half_q  <= half;
                rx_sh_q <= '0;
                if (!cpha) begin
                    mosi_q  <= aligned[15];
                    tx_sh_q <= aligned << 1;
                end else begin
                    tx_sh_q <= aligned;
                end
            end else begin
                case (st_q)
                    SH_IDLE: begin
                        sck_q <= cpol;
                        cs_q  <= 1'b1;
                    end
                    SH_RUN: begin
                        if (tick) begin
                            tmr_q  <= '0;
                            sck_q  <= ~sck_q;
                            edge_q <= edge_q + 6'd1;
                            if (sample_edge) begin
                                rx_sh_q <= rx_next[14:0];
                                if (edge_q == last_sample) begin
                                    push_q <= 1'b1;
                                    word_q <= rx_next;
                                end
                            end else begin
                                mosi_q  <= tx_sh_q[15];
                                tx_sh_q <= tx_sh_q << 1;
                            end
                            if (edge_q == last_edge) st_q <= SH_TAIL;
                        end else begin
                            tmr_q <= tmr_q + 16'd1;
                        end
                    end
                    SH_TAIL: begin
                        if (tick) begin
                            st_q  <= SH_IDLE;
                            cs_q  <= 1'b1;
                            tmr_q <= '0;
                        end else begin
                            tmr_q <= tmr_q + 16'd1;
                        end
                    end
                    default: st_q <= SH_IDLE;
                endcase
            end
        end
    end

    assign tx_pop  = load_now;
    assign rx_push = push_q;
    assign rx_data = word_q;
    assign sck     = sck_q;
    assign mosi    = mosi_q;
    assign cs_n    = cs_q;
    assign active  = (st_q != SH_IDLE);

    // R11
    cs_active_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != SH_IDLE) |-> !cs_q);

    // R4
    sck_rest_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SH_TAIL) |-> (sck_q == cpol_q));

    // R3
    edge_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SH_RUN) |-> (edge_q <= last_edge));

    // R7
    idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SH_IDLE && !en) |=> (st_q == SH_IDLE));

endmodule

// File: rtl/ssp_master.sv
module ssp_master
    import ssp_pkg::*;
#(
    parameter int FIFO_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [11:0] reg_addr,
    input  logic        reg_wr,
    input  logic [15:0] reg_wdata,
    input  logic        reg_rd,
    output logic [15:0] reg_rdata,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_n
);
    fmt_t        fmt_q;
    logic        en_q;
    logic [7:0]  presc_q;

    logic        aligned_hit;
    logic [9:0]  widx;
    logic        data_wr, data_rd;

    logic [15:0] tx_head, rx_head, rx_word;
    logic        tx_empty, tx_full, rx_empty, rx_full;
    logic        tx_pop, rx_push, active;
    status_t     stat;

    assign aligned_hit = (reg_addr[1:0] == 2'b00);
    assign widx        = reg_addr[11:2];
    assign data_wr     = reg_wr && aligned_hit && (widx == W_DATA);
    assign data_rd     = reg_rd && aligned_hit && (widx == W_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q   <= '0;
            en_q    <= 1'b0;
            presc_q <= '0;
        end else if (reg_wr && aligned_hit) begin
            case (widx)
                W_FMT:   fmt_q   <= fmt_t'(reg_wdata & FMT_WMASK);
                W_PORT:  en_q    <= reg_wdata[PORT_EN_BIT];
                W_PRESC: presc_q <= reg_wdata[7:0];
                default: ;
            endcase
        end
    end

    ssp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_txq (
        .clk(clk), .rst(rst),
        .push(data_wr), .wdata(reg_wdata),
        .pop(tx_pop), .rdata(tx_head),
        .empty(tx_empty), .full(tx_full)
    );

    ssp_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_rxq (
        .clk(clk), .rst(rst),
        .push(rx_push), .wdata(rx_word),
        .pop(data_rd), .rdata(rx_head),
        .empty(rx_empty), .full(rx_full)
    );

    ssp_shifter i_shift (
        .clk(clk), .rst(rst),
        .en(en_q),
        .cpol(fmt_q.cpol), .cpha(fmt_q.cpha),
        .size_m1(fmt_q.size_m1),
        .half(half_len(presc_q, fmt_q.rate)),
        .tx_valid(!tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_word),
        .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n),
        .active(active)
    );

    always_comb begin
        stat           = '0;
        stat.tx_empty  = tx_empty;
        stat.tx_nfull  = !tx_full;
        stat.rx_nempty = !rx_empty;
        stat.rx_full   = rx_full;
        stat.busy      = active || (en_q && !tx_empty);
    end

    always_comb begin
        reg_rdata = '0;
        if (aligned_hit) begin
            case (widx)
                W_FMT:   reg_rdata = fmt_q;
                W_PORT:  reg_rdata = {14'd0, en_q, 1'b0};
                W_DATA:  reg_rdata = rx_head;
                W_STAT:  reg_rdata = stat;
                W_PRESC: reg_rdata = {8'd0, presc_q};
                W_ID0:   reg_rdata = ID0_VAL;
                W_ID1:   reg_rdata = ID1_VAL;
                W_ID2:   reg_rdata = ID2_VAL;
                W_ID3:   reg_rdata = ID3_VAL;
                default: reg_rdata = '0;
            endcase
        end
    end

    // R8
    busy_cs_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> stat.busy);

    // R10
    rx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_full && !data_rd) |=> rx_full);

endmodule

// File: tb/test_ssp_master.sv
`timescale 1ns/1ps
module test_ssp_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        sck, mosi, cs_n;
    logic        miso = 1'b0;

    int total = 0, bad = 0;

    // slave model state
    logic        t_cpol = 1'b0, t_cpha = 1'b0, watch = 1'b0;
    int          t_n = 8;
    logic        p_sck = 1'b0, p_cs = 1'b1;
    int          s_bits = 0, s_frame = 0, cap_n = 0, cs_rises = 0, edge_bad = 0;
    logic [15:0] s_cap = '0;
    logic [15:0] cap_mem [64];
    time         t_last = 0;
    int          gap = 0;

    always #4 clk = ~clk;

    ssp_master i_ssp_master (
        .clk(clk), .rst(rst), .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
        .reg_rd(rd), .reg_rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    function automatic logic [15:0] mask(int n);
        return 16'((32'd1 << n) - 1);
    endfunction

    function automatic logic [15:0] resp(int k, int n);
        logic [15:0] v;
        v = 16'h6B1D ^ 16'(k * 16'h0F35 + k);
        return v & mask(n);
    endfunction

    function automatic logic [15:0] txw(int k);
        return 16'hC3A5 + 16'(k * 16'h1357);
    endfunction

    always @(sck or cs_n) begin
        logic [15:0] r;
        if (cs_n !== p_cs) begin
            if (cs_n === 1'b0) begin
                s_bits = 0; s_cap = '0;
                if (!t_cpha) begin r = resp(s_frame, t_n); miso = r[t_n-1]; end
            end else if (watch) cs_rises++;
            p_cs = cs_n;
        end
        if (sck !== p_sck) begin
            p_sck = sck;
            gap = int'(($time - t_last) / 8);
            t_last = $time;
            if (watch) begin
                if (cs_n !== 1'b0) edge_bad++;
                else if ((sck != t_cpol) ^ t_cpha) begin
                    s_cap = {s_cap[14:0], mosi};
                    s_bits++;
                    if (s_bits == t_n) begin
                        cap_mem[cap_n % 64] = s_cap;
                        cap_n++;
                        if (t_cpha) begin s_frame++; s_bits = 0; s_cap = '0; end
                    end
                end else if (!t_cpha) begin
                    if (s_bits == t_n) begin
                        s_frame++; s_bits = 0; s_cap = '0;
                        r = resp(s_frame, t_n); miso = r[t_n-1];
                    end else begin
                        r = resp(s_frame, t_n); miso = r[t_n-1-s_bits];
                    end
                end else begin
                    r = resp(s_frame, t_n); miso = r[t_n-1-s_bits];
                end
            end
        end
    end

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [11:0] a, logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_read(logic [11:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 20000; i++) begin
            reg_read(12'h00C, s);
            if (!s[4]) return;
        end
        chk("R8 busy timeout", 16'd1, 16'd0);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic set_fmt(logic cp, logic ph, logic [3:0] sz, logic [7:0] rate, logic [7:0] presc);
        watch = 1'b0;
        reg_write(12'h004, 16'h0000);
        reg_write(12'h000, {rate, ph, cp, 2'b00, sz});
        reg_write(12'h010, {8'd0, presc});
        t_cpol = cp; t_cpha = ph; t_n = int'(frame_len_tb(sz));
        repeat (2) @(negedge clk);
        watch = 1'b1;
    endtask

    function automatic int frame_len_tb(logic [3:0] sz);
        return (sz < 3) ? 4 : int'(sz) + 1;
    endfunction

    task automatic run_burst(int nfr, string req);
        logic [15:0] d;
        int cbase, fbase, rbase;
        cbase = cap_n; fbase = s_frame; rbase = cs_rises;
        reg_write(12'h004, 16'h0002);
        for (int k = 0; k < nfr; k++) reg_write(12'h008, txw(fbase + k));
        wait_idle();
        repeat (2) @(negedge clk);
        chk({req, " R11 cs high after burst"}, {15'd0, cs_n}, 16'd1);
        chk({req, " R11 one cs rise per burst"}, 16'(cs_rises - rbase), 16'd1);
        chk({req, " R4 sck idle level"}, {15'd0, sck}, {15'd0, t_cpol});
        chk({req, " R5 frames captured"}, 16'(cap_n - cbase), 16'(nfr));
        for (int k = 0; k < nfr; k++)
            chk({req, " R3 mosi frame"}, cap_mem[(cbase + k) % 64], txw(fbase + k) & mask(t_n));
        reg_read(12'h00C, d);
        chk({req, " R1 rx not empty"}, {15'd0, d[2]}, 16'd1);
        for (int k = 0; k < nfr; k++) begin
            reg_read(12'h008, d);
            chk({req, " R5 rx frame"}, d, resp(fbase + k, t_n));
        end
        reg_read(12'h00C, d);
        chk({req, " R1 rx drained"}, {15'd0, d[2]}, 16'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        int lens[4] = '{4, 7, 8, 16};
        int fb, cb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        reg_read(12'h00C, d); chk("R1 status after reset", d, 16'h0003);
        chk("R1 cs_n after reset", {15'd0, cs_n}, 16'd1);

        // R2 identification
        reg_read(12'hFE0, d); chk("R2 id0", d, 16'h0022);
        reg_read(12'hFE4, d); chk("R2 id1", d, 16'h0010);
        reg_read(12'hFE8, d); chk("R2 id2", d, 16'h0004);
        reg_read(12'hFEC, d); chk("R2 id3", d, 16'h0000);

        // R12 readback
        reg_write(12'h000, 16'hFFFF); reg_read(12'h000, d); chk("R12 fmt readback", d, 16'hFFCF);
        reg_write(12'h004, 16'hFFFF); reg_read(12'h004, d); chk("R12 port readback", d, 16'h0002);
        reg_write(12'h004, 16'h0000);
        reg_write(12'h010, 16'h01FF); reg_read(12'h010, d); chk("R12 prescale readback", d, 16'h00FF);
        reg_read(12'h014, d); chk("R12 unmapped reads zero", d, 16'h0000);

        // R3 R4 R5 R11 sweep over modes and lengths
        for (int m = 0; m < 4; m++)
            for (int li = 0; li < 4; li++) begin
                set_fmt(m[1], m[0], 4'(lens[li] - 1), 8'd0, 8'd2);
                run_burst(3, "R4 mode sweep");
            end

        // R3 size below minimum -> 4 bits
        set_fmt(1'b0, 1'b0, 4'd1, 8'd0, 8'd2);
        chk("R3 short setting length", 16'(t_n), 16'd4);
        run_burst(2, "R3 short frame");

        // R6 clock divisor
        set_fmt(1'b0, 1'b1, 4'd7, 8'd2, 8'd4);
        run_burst(1, "R6 rate a");
        chk("R6 half period 2x3", 16'(gap), 16'd6);
        set_fmt(1'b1, 1'b0, 4'd7, 8'd0, 8'd7);
        run_burst(1, "R6 rate b");
        chk("R6 half period 3x1", 16'(gap), 16'd3);

        // R7 R9 R10 fill while disabled
        set_fmt(1'b0, 1'b0, 4'd7, 8'd0, 8'd2);
        fb = s_frame; cb = cap_n;
        for (int k = 0; k < 9; k++) reg_write(12'h008, txw(fb + k));
        repeat (40) @(negedge clk);
        reg_read(12'h00C, d);
        chk("R9 tx full status", d & 16'h0013, 16'h0000);
        chk("R7 cs high while disabled", {15'd0, cs_n}, 16'd1);
        chk("R7 no frames while disabled", 16'(cap_n - cb), 16'd0);
        reg_write(12'h004, 16'h0002);
        wait_idle();
        chk("R9 ninth write dropped", 16'(cap_n - cb), 16'd8);
        for (int k = 0; k < 8; k++)
            chk("R9 kept frames", cap_mem[(cb + k) % 64], txw(fb + k) & 16'h00FF);
        reg_read(12'h00C, d);
        chk("R10 rx full status", d & 16'h001C, 16'h000C);
        reg_write(12'h008, 16'h005A);
        wait_idle();
        repeat (2) @(negedge clk);
        chk("R10 extra frame shifted", 16'(cap_n - cb), 16'd9);
        for (int k = 0; k < 8; k++) begin
            reg_read(12'h008, d);
            chk("R10 rx kept oldest", d, resp(fb + k, 8));
        end
        reg_read(12'h008, d); chk("R10 empty read zero", d, 16'h0000);
        reg_read(12'h00C, d); chk("R8 idle status", d, 16'h0003);
        chk("R11 no edge without select", 16'(edge_bad), 16'd0);

        finish_run();
    end

endmodule